// File: doc/BRIEF.md
# Recirculating Waveguide Delay Sequencer

This block is the delay loop of a plucked-string style resonator. Every sample is held in a single-port RAM, and the loop length is the full depth of that RAM. One pointer marks the oldest sample, which is read next, and the same slot receives the newest sample. The pointer wraps by binary overflow, so no compare or modulo logic is needed.

Each sample period begins with a one-cycle strobe. A short fixed sequence then shares the single RAM port between three accesses. It reads a pickup tap at an offset from the pointer. It reads the oldest sample, which feeds a one-pole lowpass, and in the same cycle writes back the filter result from the previous period plus an excitation sample. Finally it advances the pointer and pulses done. The pickup tap is the output that drives the rest of the synthesis path. The excitation input injects energy, for example a noise burst for a pluck.

Top module: `wg_delay_seq`

## Requirements
- R1: While reset is held and right after it, tap_out is 0 and done is 0, and the pointer, the filter state and the excitation register are zero. Reset leaves the RAM contents as they were, so values already stored are returned by later pickup reads.
- R2: A sequence starts only when sample_stb is high on a rising edge while the block is idle. A strobe that arrives while a sequence is in progress starts nothing.
- R3: done is high for exactly one clock cycle per sequence. That cycle begins at the fourth rising edge after the edge that accepted the strobe.
- R4: tap_out becomes RAM[(ptr + ofs) mod 2^ADDR_W] as stored before this period's write-back, where ptr is the pointer at the start of the period. It then holds that value until the next sequence loads it again.
- R5: The pickup offset and the excitation sample are sampled on the edge that accepts the strobe. Later changes on those inputs have no effect on that sequence.
- R6: In each period, the slot at ptr is overwritten with sat(y + e). Here y is the filter state left by the previous period and e is the excitation sampled for this period.
- R7: The value read from the slot at ptr before the write-back is x. The filter state then becomes y + ((x - y) >>> K), computed on two's-complement signed samples with an arithmetic shift (K = 2 by default).
- R8: The write-back sum saturates to the range [-2^(DATA_W-1), 2^(DATA_W-1)-1] and never wraps.
- R9: The pointer advances by exactly one per sequence and does not change at any other time. It goes from 2^ADDR_W-1 to 0, so every slot is revisited after 2^ADDR_W sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_stb | input | 1 | One-cycle request to run one sample period |
| tap_ofs | input | ADDR_W | Pickup offset added to the pointer, unsigned, wraps |
| excite | input | DATA_W | Signed excitation added before write-back |
| tap_out | output | DATA_W | Signed pickup sample, registered |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The RAM is first preloaded with a known ramp. Zero-offset reads then show that reset left the contents alone and that the pickup sees the slot before it is overwritten. The maximum offset reads the slot written one period earlier, which tells the read-before-write order apart from a wrong order. Runs longer than the RAM depth, with zero excitation, send the lowpass output back around the loop, so a wrong shift or a wrong pointer step appears at the tap. Full-scale positive and negative excitation bursts drive the sum into saturation. A strobe during a busy sequence, together with offset and excitation changes made mid-sequence, checks that those inputs are sampled once.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_TAP_RD   = 3'd1,
    ST_TAP_CAP  = 3'd2,
    ST_LOOP_RD  = 3'd3,
    ST_LOOP_CAP = 3'd4,
    ST_ADV      = 3'd5
  } seq_state_t;
endpackage

// File: rtl/wg_rst_sync.sv
module wg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wg_ram.sv
// Single-port RAM, synchronous read with one cycle latency, read-first.
module wg_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= din;
      dout <= mem[addr];
    end
  end
endmodule

// File: rtl/wg_seq_ctrl.sv
module wg_seq_ctrl
  import wg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [ADDR_W-1:0] tap_ofs,
  output seq_state_t        state_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              accept,
  output logic              ld_tap,
  output logic              ld_x,
  output logic              step_y
);
  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] ofs_q, ofs_d;
  logic [ADDR_W-1:0] tap_addr;

  assign accept   = (state_q == ST_IDLE) && sample_stb;
  assign tap_addr = ptr_q + ofs_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (sample_stb) state_d = ST_TAP_RD;
      ST_TAP_RD:   state_d = ST_TAP_CAP;
      ST_TAP_CAP:  state_d = ST_LOOP_RD;
      ST_LOOP_RD:  state_d = ST_LOOP_CAP;
      ST_LOOP_CAP: state_d = ST_ADV;
      ST_ADV:      state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ptr_d = ptr_q;
    if (state_q == ST_ADV) ptr_d = ptr_q + 1'b1;
    ofs_d = ofs_q;
    if (accept) ofs_d = tap_ofs;
  end

  always_comb begin
    ram_en   = (state_q == ST_TAP_RD) || (state_q == ST_LOOP_RD);
    ram_we   = (state_q == ST_LOOP_RD);
    ram_addr = (state_q == ST_TAP_RD) ? tap_addr : ptr_q;
    ld_tap   = (state_q == ST_TAP_CAP);
    ld_x     = (state_q == ST_LOOP_CAP);
    step_y   = (state_q == ST_ADV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      ofs_q   <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      ofs_q   <= ofs_d;
    end
  end

  assign state_o = state_q;
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/wg_lowpass.sv
// One-pole lowpass in the loop plus saturating excitation injection.
module wg_lowpass #(
  parameter int DATA_W = 16,
  parameter int K      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_exc,
  input  logic              clr_exc,
  input  logic [DATA_W-1:0] exc_in,
  input  logic              ld_x,
  input  logic [DATA_W-1:0] x_in,
  input  logic              step_y,
  output logic [DATA_W-1:0] wb_data
);
  localparam logic signed [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] exc_q, exc_d;
  logic signed [DATA_W-1:0] x_q, x_d;
  logic signed [DATA_W-1:0] y_q, y_d;
  logic signed [DATA_W:0]   diff, step, y_wide, sum;

  always_comb begin
    diff   = {x_q[DATA_W-1], x_q} - {y_q[DATA_W-1], y_q};
    step   = diff >>> K;
    y_wide = {y_q[DATA_W-1], y_q} + step;
    sum    = {y_q[DATA_W-1], y_q} + {exc_q[DATA_W-1], exc_q};
    if (sum[DATA_W] != sum[DATA_W-1]) wb_data = sum[DATA_W] ? SMIN : SMAX;
    else                              wb_data = sum[DATA_W-1:0];
  end

  always_comb begin
    exc_d = exc_q;
    if (ld_exc)       exc_d = exc_in;
    else if (clr_exc) exc_d = '0;
    x_d = ld_x   ? x_in : x_q;
    y_d = step_y ? y_wide[DATA_W-1:0] : y_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      exc_q <= exc_d;
      x_q   <= x_d;
      y_q   <= y_d;
    end
  end
endmodule

// File: rtl/wg_delay_seq.sv
module wg_delay_seq
  import wg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int K      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [ADDR_W-1:0] tap_ofs,
  input  logic [DATA_W-1:0] excite,
  output logic [DATA_W-1:0] tap_out,
  output logic              done
);
  logic              rst_sync_n;
  seq_state_t        seq_state;
  logic [ADDR_W-1:0] ptr;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_dout, wb_data;
  logic              accept, ld_tap, ld_x, step_y;
  logic [DATA_W-1:0] tap_q, tap_d;

  wg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wg_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sample_stb (sample_stb),
    .tap_ofs    (tap_ofs),
    .state_o    (seq_state),
    .ptr_o      (ptr),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .accept     (accept),
    .ld_tap     (ld_tap),
    .ld_x       (ld_x),
    .step_y     (step_y)
  );

  wg_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .din  (wb_data),
    .dout (ram_dout)
  );

  wg_lowpass #(.DATA_W(DATA_W), .K(K)) u_filt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_exc  (accept),
    .clr_exc (step_y),
    .exc_in  (excite),
    .ld_x    (ld_x),
    .x_in    (ram_dout),
    .step_y  (step_y),
    .wb_data (wb_data)
  );

  assign tap_d = ld_tap ? ram_dout : tap_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) tap_q <= '0;
    else             tap_q <= tap_d;
  end

  assign tap_out = tap_q;
  assign done    = step_y;
endmodule

// File: rtl/wg_delay_seq_chk.sv
module wg_delay_seq_chk
  import wg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic              done,
  input logic [DATA_W-1:0] tap_out,
  input seq_state_t        state,
  input logic [ADDR_W-1:0] ptr,
  input logic              ram_we
);
  AST_START_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && sample_stb) |=> (state == ST_TAP_RD)); // R2
  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (state != ST_TAP_RD)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_TAP_CAP) |=> $stable(tap_out)); // R4
  AST_WB_IN_LOOP_RD: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (state == ST_LOOP_RD)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ptr == $past(ptr) + 1'b1)); // R9
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(ptr)); // R9
endmodule

bind wg_delay_seq wg_delay_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sample_stb (sample_stb),
  .done       (done),
  .tap_out    (tap_out),
  .state      (seq_state),
  .ptr        (ptr),
  .ram_we     (ram_we)
);

// File: tb/wg_delay_seq_tb.sv
module wg_delay_seq_tb;
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int KS    = 2;
  localparam int DEPTH = 1 << AW;
  localparam int SMAX  = (1 << (DW - 1)) - 1;
  localparam int SMIN  = -(1 << (DW - 1));

  logic          clk;
  logic          rst_n;
  logic          sample_stb;
  logic [AW-1:0] tap_ofs;
  logic [DW-1:0] excite;
  logic [DW-1:0] tap_out;
  logic          done;

  int checks = 0;
  int errors = 0;
  int m_mem [DEPTH];
  int m_ptr = 0;
  int m_y   = 0;
  int exp_q [$];
  string tag_q [$];
  int done_seen = 0;
  int seq_count = 0;
  logic prev_done = 1'b0;

  wg_delay_seq #(.DATA_W(DW), .ADDR_W(AW), .K(KS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .tap_ofs    (tap_ofs),
    .excite     (excite),
    .tap_out    (tap_out),
    .done       (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int preload_val(int i);
    return ((i * 1103) % 60000) - 30000;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected pickup values as done pulses appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_seen++;
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          check(tag_q.pop_front(), $signed(tap_out), exp_q.pop_front());
        end
      end
      if (prev_done) check("R3 done width", int'(done), 0);
      prev_done = done;
    end
  end

  // Driver: updates the reference model and pushes the expected pickup.
  task automatic do_sample(int ofs, int exc, bit glitch, string tag);
    int a, x, s;
    a = (m_ptr + ofs) % DEPTH;
    exp_q.push_back(m_mem[a]);
    tag_q.push_back(tag);
    x = m_mem[m_ptr];
    s = m_y + exc;
    if (s > SMAX) s = SMAX;
    if (s < SMIN) s = SMIN;
    m_mem[m_ptr] = s;
    m_y = m_y + ((x - m_y) >>> KS);
    m_ptr = (m_ptr + 1) % DEPTH;
    seq_count++;

    sample_stb = 1'b1;
    tap_ofs    = AW'(ofs);
    excite     = DW'(exc);
    @(negedge clk);
    sample_stb = 1'b0;
    if (glitch) begin
      tap_ofs = AW'(ofs + 17);
      excite  = DW'(12345);
    end
    @(negedge clk);
    if (glitch) sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    @(negedge clk);
    check("R3 done early", int'(done), 0);
    @(negedge clk);
    check("R3 done timing", int'(done), 1);
    tap_ofs = '0;
    excite  = '0;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sample_stb = 1'b0;
    tap_ofs    = '0;
    excite     = '0;
    rst_n      = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      m_mem[i] = preload_val(i);
      u_dut.u_ram.mem[i] = DW'(preload_val(i));
    end
    repeat (3) @(negedge clk);
    check("R1 tap in reset", int'(tap_out), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 tap after reset", int'(tap_out), 0);
    check("R1 done after reset", int'(done), 0);

    // R1 / R4: RAM kept through reset, offset reads
    do_sample(0, 0, 1'b0, "R1 preload kept");
    do_sample(5, 0, 1'b0, "R4 offset tap");
    do_sample(DEPTH - 1, 0, 1'b0, "R4 max offset reads last write");

    // R7 / R9: long run around the loop, several wraps
    for (int n = 0; n < 2 * DEPTH + 7; n++)
      do_sample((n * 7) % DEPTH, 0, 1'b0, "R7 R9 loop filter wrap");

    // R6 / R8: excitation bursts into saturation
    for (int n = 0; n < 6; n++) do_sample(0, SMAX, 1'b0, "R6 R8 positive burst");
    for (int n = 0; n < 6; n++) do_sample(DEPTH - 1, SMIN, 1'b0, "R6 R8 negative burst");
    for (int n = 0; n < 10; n++) do_sample(3, (n * 4111) % 20000 - 10000, 1'b0, "R6 mixed excitation");
    for (int n = 0; n < DEPTH; n++) do_sample(n % 9, 0, 1'b0, "R7 ring-down");

    // R2 / R5: busy strobe and mid-sequence input changes
    for (int n = 0; n < 8; n++) do_sample(11 + n, 700 * n, 1'b1, "R2 R5 busy strobe and late inputs");
    for (int n = 0; n < DEPTH; n++) do_sample(DEPTH - 1 - n, 0, 1'b0, "R9 after busy strobes");

    repeat (4) @(negedge clk);
    check("R2 done count", done_seen, seq_count);
    check("R4 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule